// File: doc/BRIEF.md
# Processor Execution State Controller

This block holds the execution state of a small processor core. The core is always in exactly one of three states: normal (user code), exception (handler code) or halted. The block also drives the supervisor flag that goes with the state. Strobes from the rest of the core move it between states: a request to take an exception, a return from a handler, a write to the status register, a double bus fault, and an external halt line. The halt line is sampled only when an instruction completes.

While the core is in user mode, the block also screens the decoded class of the current instruction. Five classes are reserved for supervisor code: stop, reset, handler return, status-register write and user stack pointer move. If one of them is issued in user mode, the block raises a privilege-violation request in the same cycle. The exception entry logic feeds that request back as an exception strobe. A stall output holds the instruction pipeline for every cycle the core spends halted.

Top module: `exec_state_ctrl`

## Requirements
- R1: While reset is asserted and after its release the state is exception (code 1), `sup_o`=1, `stall_o`=0. Reset is the only exit from a fault halt.
- R2: State codes are normal=0, exception=1, halted=2, and code 3 never appears. `sup_o` is 0 only in normal, and `stall_o` is 1 exactly in halted.
- R3: `priv_viol_o` is 1 in the same cycle when the state is normal, `op_valid_i`=1 and `op_class_i` is 1 (stop), 2 (reset), 3 (handler return), 4 (status-register write) or 5 (user stack pointer move). It is 0 for classes 0, 6 and 7, when `op_valid_i`=0, and in the exception and halted states.
- R4: In normal, `exc_req_i` moves the state to exception on the next edge.
- R5: In exception, with no new request, `exc_ret_i` or `sr_wr_i` with `sr_wr_sup_i`=0 returns the state to normal. `sr_wr_i` with `sr_wr_sup_i`=1 keeps it in exception, and `exc_req_i` keeps it in exception whatever else is asserted.
- R6: `halt_i` halts the core from normal or exception only in a cycle where `insn_done_i`=1. Without that strobe it has no effect.
- R7: A halt entered through `halt_i` lasts while `halt_i`=1. On the first edge with `halt_i`=0 the state becomes normal.
- R8: `dbl_fault_i` in normal or exception moves the state to halted on the next edge. That halt ignores `halt_i` and lasts until reset.
- R9: `dbl_fault_i` while already halted is ignored, so a halt entered through `halt_i` still ends when the line is released.
- R10: Priority in normal and exception is: double fault first, then halt at an instruction boundary, then exception request and return.
- R11: In normal, `exc_ret_i` and `sr_wr_i` have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception or interrupt taken |
| exc_ret_i | input | 1 | Return from handler executed |
| sr_wr_i | input | 1 | Status register written |
| sr_wr_sup_i | input | 1 | Supervisor bit value in that write |
| halt_i | input | 1 | External halt line |
| dbl_fault_i | input | 1 | Double bus fault |
| insn_done_i | input | 1 | Instruction boundary strobe |
| op_valid_i | input | 1 | `op_class_i` is valid |
| op_class_i | input | CLS_W | Decoded instruction class |
| state_o | output | 2 | Current execution state |
| sup_o | output | 1 | Supervisor flag |
| priv_viol_o | output | 1 | Privilege-violation request |
| stall_o | output | 1 | Pipeline stall |

## Verification
A wrong state register shows up at `state_o`, `sup_o` and `stall_o` on the edge after the faulty transition. A missing or sticky fault flag shows up later: it appears only on the first cycle that `halt_i` is low while the core is halted, because the state then either leaves halted when it should stay or stays when it should leave. A wrong privilege filter shows in the same cycle as the offending class, and only while the state is normal. So every transition is tried from every starting state, including both kinds of halt, and every class is tried in every state.

// File: rtl/exec_state_pkg.sv
package exec_state_pkg;
  typedef enum logic [1:0] {
    XS_RUN  = 2'd0,
    XS_TRAP = 2'd1,
    XS_HALT = 2'd2
  } xstate_e;

  localparam int unsigned OPC_STOP   = 1;
  localparam int unsigned OPC_RESET  = 2;
  localparam int unsigned OPC_RETURN = 3;
  localparam int unsigned OPC_SRWR   = 4;
  localparam int unsigned OPC_USPMV  = 5;
endpackage

// File: rtl/est_priv_filter.sv
module est_priv_filter
  import exec_state_pkg::*;
#(
  parameter int unsigned CLS_W = 3
) (
  input  logic             user_mode,
  input  logic             op_valid,
  input  logic [CLS_W-1:0] op_class,
  output logic             viol
);
  function automatic logic reserved_class(input logic [CLS_W-1:0] c);
    int unsigned v;
    v = int'(c);
    return (v == OPC_STOP) || (v == OPC_RESET) || (v == OPC_RETURN) ||
           (v == OPC_SRWR) || (v == OPC_USPMV);
  endfunction

  always_comb viol = user_mode && op_valid && reserved_class(op_class);
endmodule

// File: rtl/est_halt_ctrl.sv
module est_halt_ctrl
  import exec_state_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  xstate_e cur,
  input  logic    halt_line,
  input  logic    insn_done,
  input  logic    dbl_fault,
  output logic    halt_enter,
  output logic    halt_leave,
  output logic    fault_halt
);
  logic at_boundary;
  logic fault_take;
  logic fault_q;

  always_comb begin
    at_boundary = halt_line && insn_done;
    fault_take  = (cur != XS_HALT) && dbl_fault;
    halt_enter  = (cur != XS_HALT) && (dbl_fault || at_boundary);
    halt_leave  = (cur == XS_HALT) && !fault_q && !halt_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fault_q <= 1'b0;
    else if (fault_take) fault_q <= 1'b1;
  end

  assign fault_halt = fault_q;

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == XS_HALT && fault_q) |=> (cur == XS_HALT));
endmodule

// File: rtl/est_next_state.sv
module est_next_state
  import exec_state_pkg::*;
(
  input  xstate_e cur,
  input  logic    exc_req,
  input  logic    exc_ret,
  input  logic    sr_wr,
  input  logic    sr_wr_sup,
  input  logic    halt_enter,
  input  logic    halt_leave,
  output xstate_e nxt
);
  function automatic xstate_e step_fn(input xstate_e s, input logic req,
                                      input logic ret, input logic drop_sup,
                                      input logic h_in, input logic h_out);
    if (h_in) return XS_HALT;
    case (s)
      XS_RUN:  return req ? XS_TRAP : XS_RUN;
      XS_TRAP: return req ? XS_TRAP : ((ret || drop_sup) ? XS_RUN : XS_TRAP);
      XS_HALT: return h_out ? XS_RUN : XS_HALT;
      default: return XS_TRAP;
    endcase
  endfunction

  always_comb nxt = step_fn(cur, exc_req, exc_ret, sr_wr && !sr_wr_sup,
                            halt_enter, halt_leave);
endmodule

// File: rtl/exec_state_ctrl.sv
module exec_state_ctrl
  import exec_state_pkg::*;
#(
  parameter int unsigned CLS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req_i,
  input  logic             exc_ret_i,
  input  logic             sr_wr_i,
  input  logic             sr_wr_sup_i,
  input  logic             halt_i,
  input  logic             dbl_fault_i,
  input  logic             insn_done_i,
  input  logic             op_valid_i,
  input  logic [CLS_W-1:0] op_class_i,
  output logic [1:0]       state_o,
  output logic             sup_o,
  output logic             priv_viol_o,
  output logic             stall_o
);
  xstate_e state_q;
  xstate_e state_d;
  logic    halt_enter;
  logic    halt_leave;
  logic    fault_halt;
  logic    user_mode;

  assign user_mode = (state_q == XS_RUN);

  est_halt_ctrl u_halt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur        (state_q),
    .halt_line  (halt_i),
    .insn_done  (insn_done_i),
    .dbl_fault  (dbl_fault_i),
    .halt_enter (halt_enter),
    .halt_leave (halt_leave),
    .fault_halt (fault_halt)
  );

  est_next_state u_next (
    .cur        (state_q),
    .exc_req    (exc_req_i),
    .exc_ret    (exc_ret_i),
    .sr_wr      (sr_wr_i),
    .sr_wr_sup  (sr_wr_sup_i),
    .halt_enter (halt_enter),
    .halt_leave (halt_leave),
    .nxt        (state_d)
  );

  est_priv_filter #(.CLS_W(CLS_W)) u_priv (
    .user_mode (user_mode),
    .op_valid  (op_valid_i),
    .op_class  (op_class_i),
    .viol      (priv_viol_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= XS_TRAP;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign sup_o   = (state_q != XS_RUN);
  assign stall_o = (state_q == XS_HALT);

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);

  // R3
  viol_user_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol_o |-> (state_o == 2'd0 && !sup_o));

  // R4
  trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && exc_req_i && !dbl_fault_i && !(halt_i && insn_done_i))
    |=> (state_o == 2'd1 && sup_o));

  // R5
  trap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && !exc_req_i && exc_ret_i && !dbl_fault_i &&
     !(halt_i && insn_done_i)) |=> (state_o == 2'd0));

  // R6
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd2 && !dbl_fault_i && !insn_done_i) |=> !stall_o);

  // R7
  halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !fault_halt && !halt_i) |=> (state_o == 2'd0));

  // R8
  fault_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && dbl_fault_i) |=> (stall_o && fault_halt));
endmodule

// File: tb/test_exec_state_ctrl.sv
`timescale 1ns/1ps
module test_exec_state_ctrl;
  localparam int CLS_W = 3;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic exc_req = 0, exc_ret = 0, sr_wr = 0, sr_sup = 0;
  logic halt = 0, dfault = 0, idone = 0, opv = 0;
  logic [CLS_W-1:0] opc = '0;
  logic [1:0] state;
  logic sup, viol, stall;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  exec_state_ctrl #(.CLS_W(CLS_W)) i_exec_state_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_ret_i(exc_ret),
    .sr_wr_i(sr_wr), .sr_wr_sup_i(sr_sup), .halt_i(halt),
    .dbl_fault_i(dfault), .insn_done_i(idone), .op_valid_i(opv),
    .op_class_i(opc), .state_o(state), .sup_o(sup),
    .priv_viol_o(viol), .stall_o(stall));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // packed view {state, sup, stall} derived from state code alone (R2)
  function automatic logic [7:0] view(input int st);
    return 8'((st << 2) | ((st != 0) ? 2 : 0) | ((st == 2) ? 1 : 0));
  endfunction

  function automatic logic [7:0] now_view();
    return {4'd0, state, sup, stall};
  endfunction

  task automatic clr();
    exc_req = 0; exc_ret = 0; sr_wr = 0; sr_sup = 0;
    halt = 0; dfault = 0; idone = 0; opv = 0; opc = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    clr();
    rst_n = 0;
    step();
    rst_n = 1;
  endtask

  // 0 normal, 1 exception, 2 halted by line, 3 halted by fault
  task automatic reach(input int which);
    do_reset();
    if (which == 0 || which == 2) begin
      exc_ret = 1; step(); clr();
    end
    if (which == 2) begin
      halt = 1; idone = 1; step(); idone = 0;
    end
    if (which == 3) begin
      dfault = 1; step(); clr();
    end
    chk("R1 setup", now_view(), view(which == 3 ? 2 : which));
  endtask

  // v: [0]req [1]ret [2]srwr [3]srsup [4]halt [5]dfault [6]idone
  function automatic int exp_next(input int st, input bit fh, input logic [6:0] v);
    if (st == 2) return (fh || v[4]) ? 2 : 0;
    if (v[5]) return 2;
    if (v[4] && v[6]) return 2;
    if (st == 0) return v[0] ? 1 : 0;
    if (v[0]) return 1;
    return (v[1] || (v[2] && !v[3])) ? 0 : 1;
  endfunction

  function automatic string tag_of(input int st, input bit fh, input logic [6:0] v);
    if (st == 2) return fh ? "R8" : (v[5] ? "R9" : "R7");
    if (v[5]) return "R8/R10";
    if (v[4] && v[6]) return "R6/R10";
    if (v[4]) return "R6";
    if (st == 0) return v[0] ? "R4" : "R11";
    return "R5";
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: state during reset and after release
    clr();
    step();
    chk("R1 in reset", now_view(), view(1));
    rst_n = 1;
    opv = 1; opc = 3'd1;
    #2;
    chk("R1 no viol", {7'd0, viol}, 8'd0);
    step();
    chk("R1 after reset", now_view(), view(1));

    // full transition sweep from every start state (R2 view)
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 128; v++) begin
        logic [6:0] b;
        int st;
        bit fh;
        b = 7'(v);
        st = (s == 3) ? 2 : s;
        fh = (s == 3);
        reach(s);
        exc_req = b[0]; exc_ret = b[1]; sr_wr = b[2]; sr_sup = b[3];
        halt = b[4]; dfault = b[5]; idone = b[6];
        step();
        chk({"R2 ", tag_of(st, fh, b)}, now_view(), view(exp_next(st, fh, b)));
      end
    end

    // R3: class filter in normal, exception and halted
    for (int s = 0; s < 3; s++) begin
      reach(s);
      for (int ov = 0; ov < 2; ov++) begin
        for (int c = 0; c < 8; c++) begin
          opv = ov[0]; opc = 3'(c);
          #2;
          chk("R3 viol", {7'd0, viol},
              {7'd0, (s == 0 && ov == 1 && c >= 1 && c <= 5)});
          #1;
        end
      end
      opv = 0;
      step();
      chk("R3 state kept", now_view(), view(s));
    end

    // R9: fault during line halt ignored, release still resumes
    reach(2);
    dfault = 1; halt = 1;
    step();
    chk("R9 still halted", now_view(), view(2));
    clr();
    step();
    chk("R9 release to normal", now_view(), view(0));

    // R8: fault halt persists, line low for many cycles, reset exits
    reach(3);
    for (int k = 0; k < 5; k++) begin
      halt = k[0];
      step();
      chk("R8 sticky", now_view(), view(2));
    end
    clr();
    rst_n = 0;
    #2;
    chk("R1 reset exits fault halt", now_view(), view(1));
    step();
    rst_n = 1;
    step();
    chk("R1 after fault reset", now_view(), view(1));

    // R6: line held without boundary strobe for many cycles
    reach(0);
    halt = 1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R6 no boundary", now_view(), view(0));
    end
    idone = 1;
    step();
    chk("R6 boundary halt", now_view(), view(2));

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule